// File: doc/BRIEF.md
# Grouped Interrupt Status Aggregator

This block collects single-cycle event pulses from on-chip peripherals (two timer overflows, two general timer bases, the UART/SPI path, the ADC, external pins and key change) into a sticky 16-bit status register. A separate 16-bit enable register selects which of those bits may raise an interrupt. Five level-sensitive request lines come out. Each line is the OR of enable AND status over its own fixed, non-contiguous group of bits.

A built-in periodic timebase also sets status bits. It is stepped by a strobe that arrives at 4096 Hz. Every strobe sets the fastest bit. A divider chain derives the 2048 Hz, 1024 Hz and 4 Hz bits from it. Software clears status bits by writing ones to them and replaces the enable register with a plain write. The request lines are registered, so each line follows a status or enable change one clock later.

Both register writes go through a single write port, and a selector picks the target. Control and status pins are plain levels, and no handshake is involved.

Top module: `irq_group_agg`

## Requirements
- R1: After reset the status register, the enable register and all five request lines are 0.
- R2: An event pulse on `event_i[b]` sets status bit b at the next clock edge. A set status bit stays set until software clears it.
- R3: A write with `wr_sel_i` = 0 clears every status bit written as 1 and leaves the others unchanged. If an event or timebase set hits the same bit in the same cycle, the bit ends up set.
- R4: A write with `wr_sel_i` = 1 replaces the enable register with `wr_data_i`. Without such a write, the enable register holds its value.
- R5: `irq_timer_o` is 1 exactly when status AND enable has bit 11 or bit 10 set, one cycle after that condition.
- R6: `irq_data_o` follows bits 8, 13 and 14 in the same way.
- R7: `irq_ext_o` follows bits 9 and 12 in the same way.
- R8: `irq_hifreq_o` follows bits 4, 5 and 6 in the same way.
- R9: `irq_lofreq_o` follows bits 0, 1, 3 and 7 in the same way. Bits 2 and 15 drive no line.
- R10: Every `base_tick_i` strobe sets status bit 6.
- R11: Every 2nd strobe also sets bit 5. Every 2nd bit-5 event, which is every 4th strobe, also sets bit 4. The divider counters start from zero after reset.
- R12: Every DIV_LO-th bit-4 event also sets bit 3. With the default of 256, that is every 1024th strobe.
- R13: A write to the enable register alone re-evaluates all five lines. A line rises or falls one cycle later with no status change.
- R14: The lines are levels. A line stays asserted for as long as its enabled status bits remain set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick_i | input | 1 | 4096 Hz timebase strobe, one cycle wide |
| event_i | input | 16 | Per-bit event pulses that set status bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 clears status bits, 1 loads the enable register |
| wr_data_i | input | 16 | Write data |
| status_o | output | 16 | Current status register |
| enable_o | output | 16 | Current enable register |
| irq_timer_o | output | 1 | Timer overflow request line |
| irq_data_o | output | 1 | Communication and ADC request line |
| irq_ext_o | output | 1 | External pin request line |
| irq_hifreq_o | output | 1 | High-rate periodic request line |
| irq_lofreq_o | output | 1 | Low-rate periodic, timer base and key request line |

## Verification
The bench builds the block with DIV_LO lowered to 16. With that value the 4 Hz bit fires every 64 strobes instead of every 1024, so several wraps of the full divider chain fit into a short run, and the phase of the bit-3 pulse can be checked exactly. DIV_A and DIV_B keep their value of 2, because the 2048 Hz and 1024 Hz relationships are fixed behaviour and are checked as they are.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SW     = 16;
  localparam int NLINES = 5;

  typedef logic [SW-1:0] word_t;

  // line order: timer, data, external, high-rate periodic, low-rate periodic
  localparam word_t LINE_MASK [NLINES] = '{
    16'h0C00, 16'h6100, 16'h1200, 16'h0070, 16'h008B
  };

  localparam int BIT_F4K = 6;
  localparam int BIT_F2K = 5;
  localparam int BIT_F1K = 4;
  localparam int BIT_F4H = 3;

  typedef enum logic { SEL_STATUS_CLR = 1'b0, SEL_ENABLE = 1'b1 } wsel_e;
endpackage

// File: rtl/irq_div_stage.sv
module irq_div_stage #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic wrap_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_timebase.sv
module irq_timebase
  import irq_agg_pkg::*;
#(
  parameter int DIV_A  = 2,
  parameter int DIV_B  = 2,
  parameter int DIV_LO = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  output word_t set_o
);
  localparam int NST = 3;
  localparam int STAGE_DIV [NST] = '{DIV_A, DIV_B, DIV_LO};
  localparam int STAGE_BIT [NST] = '{BIT_F2K, BIT_F1K, BIT_F4H};

  logic [NST:0] step;
  assign step[0] = tick_i;

  for (genvar s = 0; s < NST; s++) begin : g_stage
    irq_div_stage #(.DIV(STAGE_DIV[s])) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .step_i(step[s]),
      .wrap_o(step[s+1])
    );
  end

  always_comb begin
    set_o = '0;
    set_o[BIT_F4K] = step[0];
    for (int s = 0; s < NST; s++) begin
      set_o[STAGE_BIT[s]] = step[s+1];
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t set_i,
  input  logic  wr_en_i,
  input  logic  wr_sel_i,
  input  word_t wr_data_i,
  output word_t status_q,
  output word_t enable_q
);
  word_t clr;

  always_comb begin
    clr = '0;
    if (wr_en_i && (wsel_e'(wr_sel_i) == SEL_STATUS_CLR)) clr = wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clr) | set_i;
      if (wr_en_i && (wsel_e'(wr_sel_i) == SEL_ENABLE)) enable_q <= wr_data_i;
    end
  end
endmodule

// File: rtl/irq_line_reduce.sv
module irq_line_reduce
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  word_t             status_i,
  input  word_t             enable_i,
  output logic [NLINES-1:0] line_q
);
  word_t live;
  assign live = status_i & enable_i;

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) line_q[l] <= 1'b0;
      else        line_q[l] <= |(live & LINE_MASK[l]);
    end
  end
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import irq_agg_pkg::*;
#(
  parameter int DIV_A  = 2,
  parameter int DIV_B  = 2,
  parameter int DIV_LO = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_tick_i,
  input  logic [15:0] event_i,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] status_o,
  output logic [15:0] enable_o,
  output logic        irq_timer_o,
  output logic        irq_data_o,
  output logic        irq_ext_o,
  output logic        irq_hifreq_o,
  output logic        irq_lofreq_o
);
  word_t             tb_set;
  word_t             st_q;
  word_t             en_q;
  logic [NLINES-1:0] lines;

  irq_timebase #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_LO(DIV_LO)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_i(base_tick_i),
    .set_o (tb_set)
  );

  irq_status_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (tb_set | event_i),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .status_q (st_q),
    .enable_q (en_q)
  );

  irq_line_reduce u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .status_i(st_q),
    .enable_i(en_q),
    .line_q  (lines)
  );

  assign status_o     = st_q;
  assign enable_o     = en_q;
  assign irq_timer_o  = lines[0];
  assign irq_data_o   = lines[1];
  assign irq_ext_o    = lines[2];
  assign irq_hifreq_o = lines[3];
  assign irq_lofreq_o = lines[4];
endmodule

// File: rtl/irq_group_agg_chk.sv
module irq_group_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        base_tick_i,
  input logic [15:0] event_i,
  input logic        wr_en_i,
  input logic        wr_sel_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] status_o,
  input logic [15:0] enable_o,
  input logic        irq_timer_o,
  input logic        irq_data_o,
  input logic        irq_ext_o,
  input logic        irq_hifreq_o,
  input logic        irq_lofreq_o
);
  logic [15:0] live;
  assign live = status_o & enable_o;

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_i) |=> ((status_o & $past(event_i)) == $past(event_i)));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && !wr_sel_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R3: bits written 1 are gone unless an event or the timebase (bits 6..3) set them
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_sel_i) |=>
      ((status_o & $past(wr_data_i & ~event_i) & 16'hFF87) == 16'h0000));

  a_r4_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i) |=> (enable_o == $past(wr_data_i)));

  a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_sel_i) |=> $stable(enable_o));

  a_r5_timer_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_timer_o == $past(|(live & 16'h0C00))));

  a_r6_data_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_data_o == $past(|(live & 16'h6100))));

  a_r7_ext_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_ext_o == $past(|(live & 16'h1200))));

  a_r8_hifreq_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_hifreq_o == $past(|(live & 16'h0070))));

  a_r9_lofreq_line: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_lofreq_o == $past(|(live & 16'h008B))));

  a_r10_base_tick: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick_i |=> status_o[6]);

  a_r11_rate_order: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_tick_i && !status_o[6] && !(|event_i[6:3])) |=> !$rose(status_o[5]) && !$rose(status_o[4]));
endmodule

bind irq_group_agg irq_group_agg_chk u_chk (.*);

// File: tb/irq_group_agg_tb.sv
module irq_group_agg_tb;
  localparam int TB_DIV_LO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick_i = 1'b0;
  logic [15:0] event_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] status_o, enable_o;
  logic        irq_timer_o, irq_data_o, irq_ext_o, irq_hifreq_o, irq_lofreq_o;

  int total = 0;
  int bad   = 0;

  logic [15:0] ms, me;
  logic [4:0]  mirq;
  int          m_a, m_b, m_lo;

  always #10 clk = ~clk;

  irq_group_agg #(.DIV_A(2), .DIV_B(2), .DIV_LO(TB_DIV_LO)) u_dut (
    .clk(clk), .rst_n(rst_n), .base_tick_i(base_tick_i), .event_i(event_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .status_o(status_o), .enable_o(enable_o),
    .irq_timer_o(irq_timer_o), .irq_data_o(irq_data_o), .irq_ext_o(irq_ext_o),
    .irq_hifreq_o(irq_hifreq_o), .irq_lofreq_o(irq_lofreq_o)
  );

  function automatic logic [4:0] lines_of(logic [15:0] s, logic [15:0] e);
    logic [15:0] v = s & e;
    return {|(v & 16'h008B), |(v & 16'h0070), |(v & 16'h1200),
            |(v & 16'h6100), |(v & 16'h0C00)};
  endfunction

  function automatic logic [4:0] dut_lines();
    return {irq_lofreq_o, irq_hifreq_o, irq_ext_o, irq_data_o, irq_timer_o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic [15:0] ev, input logic we,
                      input logic sel, input logic [15:0] d);
    logic [15:0] tbset = '0;
    logic [15:0] clr;
    logic [15:0] ns, ne;
    logic [4:0]  nirq;
    base_tick_i = tk; event_i = ev; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    if (tk) begin
      tbset[6] = 1'b1;
      m_a++;
      if (m_a == 2) begin
        m_a = 0; tbset[5] = 1'b1; m_b++;
        if (m_b == 2) begin
          m_b = 0; tbset[4] = 1'b1; m_lo++;
          if (m_lo == TB_DIV_LO) begin m_lo = 0; tbset[3] = 1'b1; end
        end
      end
    end
    clr  = (we && !sel) ? d : 16'h0000;
    ns   = (ms & ~clr) | ev | tbset;
    ne   = (we && sel) ? d : me;
    nirq = lines_of(ms, me);
    @(posedge clk); #2;
    ms = ns; me = ne; mirq = nirq;
    chk(status_o == ms, "R2/R3 status", {16'h0, status_o}, {16'h0, ms});
    chk(enable_o == me, "R4 enable", {16'h0, enable_o}, {16'h0, me});
    chk(irq_timer_o  == mirq[0], "R5 timer line",  {31'h0, irq_timer_o},  {31'h0, mirq[0]});
    chk(irq_data_o   == mirq[1], "R6 data line",   {31'h0, irq_data_o},   {31'h0, mirq[1]});
    chk(irq_ext_o    == mirq[2], "R7 ext line",    {31'h0, irq_ext_o},    {31'h0, mirq[2]});
    chk(irq_hifreq_o == mirq[3], "R8 hifreq line", {31'h0, irq_hifreq_o}, {31'h0, mirq[3]});
    chk(irq_lofreq_o == mirq[4], "R9 lofreq line", {31'h0, irq_lofreq_o}, {31'h0, mirq[4]});
    @(negedge clk);
    base_tick_i = 1'b0; event_i = '0; wr_en_i = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 16'h0, 1'b0, 1'b0, 16'h0);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    ms = '0; me = '0; mirq = '0; m_a = 0; m_b = 0; m_lo = 0;
    repeat (3) @(posedge clk);
    #2;
    chk(status_o == 16'h0 && enable_o == 16'h0, "R1 reset regs",
        {status_o, enable_o}, 32'h0);
    chk(dut_lines() == 5'b0, "R1 reset lines", {27'h0, dut_lines()}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R10, R11: divider phases from reset
    step(1'b1, 16'h0, 1'b0, 1'b0, 16'h0);
    chk(status_o == 16'h0040, "R10 first tick", {16'h0, status_o}, 32'h0040);
    step(1'b1, 16'h0, 1'b0, 1'b0, 16'h0);
    chk(status_o == 16'h0060, "R11 second tick", {16'h0, status_o}, 32'h0060);
    step(1'b0, 16'h0, 1'b1, 1'b0, 16'hFFFF);
    step(1'b1, 16'h0, 1'b0, 1'b0, 16'h0);
    step(1'b1, 16'h0, 1'b0, 1'b0, 16'h0);
    chk(status_o == 16'h0070, "R11 fourth tick", {16'h0, status_o}, 32'h0070);
    // R12: bit 3 appears on tick 4*DIV_LO
    for (int i = 5; i < 4 * TB_DIV_LO; i++) step(1'b1, 16'h0, 1'b0, 1'b0, 16'h0);
    chk(status_o[3] == 1'b0, "R12 before wrap", {31'h0, status_o[3]}, 32'h0);
    step(1'b1, 16'h0, 1'b0, 1'b0, 16'h0);
    chk(status_o[3] == 1'b1, "R12 at wrap", {31'h0, status_o[3]}, 32'h1);

    // R3: event and clear on the same bit, set wins
    step(1'b0, 16'h0, 1'b1, 1'b0, 16'hFFFF);
    step(1'b0, 16'h0100, 1'b1, 1'b0, 16'h0100);
    chk(status_o == 16'h0100, "R3 set beats clear", {16'h0, status_o}, 32'h0100);

    // R13, R14: enable write alone moves the line, level held
    step(1'b0, 16'h0400, 1'b0, 1'b0, 16'h0);
    idle();
    chk(irq_timer_o == 1'b0, "R13 disabled line low", {31'h0, irq_timer_o}, 32'h0);
    step(1'b0, 16'h0, 1'b1, 1'b1, 16'h0400);
    idle();
    chk(irq_timer_o == 1'b1, "R13 enable raises line", {31'h0, irq_timer_o}, 32'h1);
    repeat (5) idle();
    chk(irq_timer_o == 1'b1, "R14 level held", {31'h0, irq_timer_o}, 32'h1);
    step(1'b0, 16'h0, 1'b1, 1'b1, 16'h0000);
    idle();
    chk(irq_timer_o == 1'b0, "R13 disable drops line", {31'h0, irq_timer_o}, 32'h0);
    // R9: bits 2 and 15 drive no line
    step(1'b0, 16'h0, 1'b1, 1'b0, 16'hFFFF);
    step(1'b0, 16'h8004, 1'b1, 1'b1, 16'hFFFF);
    idle();
    chk(dut_lines() == 5'b0, "R9 unmapped bits", {27'h0, dut_lines()}, 32'h0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic        tk  = ($urandom() % 4) == 0;
      logic [15:0] ev  = 16'($urandom() & $urandom() & $urandom());
      logic        we  = ($urandom() % 5) == 0;
      logic        sel = 1'($urandom());
      logic [15:0] d   = 16'($urandom());
      step(tk, ev, we, sel, d);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule